// File: doc/BRIEF.md
# Core Timer with Watchdog

This block is a free-running timebase that runs on the oscillator clock. A three-stage divider feeds a binary counter chain, and together they form one long count of oscillator cycles. The block takes three things from that chain. The first is a byte that advances once every eight oscillator cycles and that software can read at any time. The second is a periodic overflow flag. The third is a real-time interrupt flag whose period is picked from four chain taps by a two-bit rate code. Each flag stays set until its own clear strobe arrives. Each flag drives an interrupt request output only while its enable input is high.

A four-stage watchdog counter counts real-time interrupt ticks while it is enabled. Software restarts it with a clear strobe. That strobe zeroes only the watchdog stages, so the timeout lands between seven and eight interrupt periods after the clear. When the watchdog expires, the block gives a one-cycle reset pulse and goes back to its startup phase.

The startup phase also runs after power-on. During this phase the chain counts out a startup delay whose length is chosen by a configuration input. When the delay ends, the chain is cleared and the release output rises.

Top module: `ct_core_timer`

## Requirements
- R1: While power-on reset is low, the count byte, both flags, both interrupt requests, the watchdog reset and the release output are all 0.
- R2: After power-on reset, or after a watchdog reset, the release output rises a fixed number of oscillator cycles later and the chain restarts from zero at that point. The delay is DLY_SHORT cycles (default 32) when `delay_long` is 0 and DLY_LONG cycles (default 8128) when it is 1. The flags stay at 0 while release is low.
- R3: Once release is high, the count byte equals the number of oscillator cycles since release, divided by 8 (integer division), modulo 256.
- R4: The overflow flag sets every 2048 oscillator cycles after release. It stays set until `ovf_clr` is sampled high. If a set and a clear arrive in the same cycle, the set wins.
- R5: The real-time interrupt flag sets every 2^(RTI_TAP0+code) oscillator cycles after release, where code is the value held in the rate register. Code 00 gives the shortest period and code 11 the longest. A write through `rate_we` and `rate_in` loads the rate register only while release is high. Every startup leaves the register at 11. Clearing the flag follows the same rule as the overflow flag.
- R6: `ovf_irq` is high exactly when the overflow flag and `ovf_ie` are both high. `rti_irq` is high exactly when the interrupt flag and `rti_ie` are both high.
- R7: While `wdog_en` is high, the watchdog counts interrupt ticks. On the eighth tick after its last clear, `wdog_rst` pulses high for one cycle. The timeout therefore falls more than 7 and at most 8 interrupt periods after the clear. On the next cycle release drops and startup begins again.
- R8: A `wdog_clr` strobe zeroes only the watchdog stages. The count byte and the flags carry on undisturbed.
- R9: While `wdog_en` is low, `wdog_rst` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| delay_long | input | 1 | Selects the long startup delay |
| rate_we | input | 1 | Loads `rate_in` into the rate register |
| rate_in | input | 2 | New interrupt rate code |
| wdog_en | input | 1 | Watchdog enable |
| wdog_clr | input | 1 | Watchdog clear strobe |
| ovf_clr | input | 1 | Overflow flag clear strobe |
| rti_clr | input | 1 | Interrupt flag clear strobe |
| ovf_ie | input | 1 | Overflow interrupt enable |
| rti_ie | input | 1 | Real-time interrupt enable |
| count | output | 8 | Readable count byte |
| ovf_flag | output | 1 | Timer overflow flag |
| rti_flag | output | 1 | Real-time interrupt flag |
| ovf_irq | output | 1 | Gated overflow request |
| rti_irq | output | 1 | Gated real-time request |
| wdog_rst | output | 1 | One-cycle watchdog reset pulse |
| rst_release | output | 1 | High once the startup delay has ended |

## Verification
The bench measures the gap between the last watchdog clear and the reset pulse and requires it to fall inside the seven-to-eight-period window. A design that cleared the whole chain on a watchdog clear, or that fired on the seventh tick, would land outside that window. The bench also times both startup delays and the first interrupt after a watchdog restart. A chain that was not cleared at release, or a rate register that did not return to code 11, would shift those edges. Finally, the bench walks the rate code through all four values and exercises clears that arrive while a flag is held. A wrong tap or a clear that beat a set would show up as a mismatch against the per-cycle model.

// File: rtl/ct_pkg.sv
package ct_pkg;

    typedef enum logic {
        PH_START = 1'b0,
        PH_RUN   = 1'b1
    } phase_t;

    typedef struct packed {
        logic       ovf;
        logic       rti;
        logic [1:0] sel;
    } ctl_s;

endpackage

// File: rtl/ct_chain.sv
module ct_chain
    import ct_pkg::*;
#(
    parameter int PRE_W     = 3,
    parameter int CNT_W     = 15,
    parameter int DLY_SHORT = 32,
    parameter int DLY_LONG  = 8128
) (
    input  logic                   clk,
    input  logic                   por_n,
    input  logic                   restart,
    input  logic                   delay_long,
    output logic [PRE_W+CNT_W-1:0] chain,
    output logic                   running
);
    localparam int TOT = PRE_W + CNT_W;
    localparam logic [TOT-1:0] LIM_S = TOT'(DLY_SHORT - 1);
    localparam logic [TOT-1:0] LIM_L = TOT'(DLY_LONG - 1);

    typedef struct packed {
        phase_t         ph;
        logic [TOT-1:0] ch;
    } chain_s;

    chain_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (restart) begin
            s_d.ph = PH_START;
            s_d.ch = '0;
        end else if (s_q.ph == PH_START &&
                     s_q.ch == (delay_long ? LIM_L : LIM_S)) begin
            s_d.ph = PH_RUN;
            s_d.ch = '0;
        end else begin
            s_d.ch = s_q.ch + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) s_q <= '{ph: PH_START, ch: '0};
        else        s_q <= s_d;
    end

    assign chain   = s_q.ch;
    assign running = (s_q.ph == PH_RUN);
endmodule

// File: rtl/ct_tick_gen.sv
module ct_tick_gen #(
    parameter int TOT      = 18,
    parameter int OVF_BIT  = 11,
    parameter int RTI_TAP0 = 15
) (
    input  logic [TOT-1:0] chain,
    input  logic [1:0]     sel,
    output logic           ovf_hit,
    output logic           rti_hit
);
    localparam int NTAP = 4;

    logic [NTAP-1:0] hit;

    for (genvar g = 0; g < NTAP; g++) begin : g_tap
        assign hit[g] = &chain[RTI_TAP0+g-1:0];
    end

    assign rti_hit = hit[sel];
    assign ovf_hit = &chain[OVF_BIT-1:0];
endmodule

// File: rtl/ct_ctrl.sv
module ct_ctrl
    import ct_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       restart,
    input  logic       running,
    input  logic       ovf_hit,
    input  logic       rti_hit,
    input  logic       ovf_clr,
    input  logic       rti_clr,
    input  logic       rate_we,
    input  logic [1:0] rate_in,
    output logic       ovf_flag,
    output logic       rti_flag,
    output logic [1:0] sel
);
    ctl_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (restart || !running) begin
            s_d = '{ovf: 1'b0, rti: 1'b0, sel: 2'b11};
        end else begin
            if (rate_we) s_d.sel = rate_in;
            if (ovf_hit)      s_d.ovf = 1'b1;
            else if (ovf_clr) s_d.ovf = 1'b0;
            if (rti_hit)      s_d.rti = 1'b1;
            else if (rti_clr) s_d.rti = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) s_q <= '{ovf: 1'b0, rti: 1'b0, sel: 2'b11};
        else        s_q <= s_d;
    end

    assign ovf_flag = s_q.ovf;
    assign rti_flag = s_q.rti;
    assign sel      = s_q.sel;
endmodule

// File: rtl/ct_watchdog.sv
module ct_watchdog #(
    parameter int WD_W = 4
) (
    input  logic clk,
    input  logic por_n,
    input  logic running,
    input  logic enable,
    input  logic clear,
    input  logic tick,
    output logic fire
);
    localparam logic [WD_W-1:0] LAST = WD_W'((1 << (WD_W - 1)) - 1);

    typedef struct packed {
        logic [WD_W-1:0] cnt;
        logic            fire;
    } wd_s;

    wd_s s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.fire = running && enable && tick && !clear && (s_q.cnt == LAST);
        if (!running || !enable || clear || s_d.fire) s_d.cnt = '0;
        else if (tick)                                s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fire = s_q.fire;
endmodule

// File: rtl/ct_core_timer.sv
module ct_core_timer #(
    parameter int PRE_W     = 3,
    parameter int CNT_W     = 15,
    parameter int OVF_STAGE = 8,
    parameter int RTI_TAP0  = 15,
    parameter int WD_W      = 4,
    parameter int DLY_SHORT = 32,
    parameter int DLY_LONG  = 8128
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       delay_long,
    input  logic       rate_we,
    input  logic [1:0] rate_in,
    input  logic       wdog_en,
    input  logic       wdog_clr,
    input  logic       ovf_clr,
    input  logic       rti_clr,
    input  logic       ovf_ie,
    input  logic       rti_ie,
    output logic [7:0] count,
    output logic       ovf_flag,
    output logic       rti_flag,
    output logic       ovf_irq,
    output logic       rti_irq,
    output logic       wdog_rst,
    output logic       rst_release
);
    localparam int TOT     = PRE_W + CNT_W;
    localparam int OVF_BIT = PRE_W + OVF_STAGE;
    localparam int BYTE_W  = 8;

    logic [TOT-1:0] chain;
    logic           running;
    logic           ovf_hit, rti_hit;
    logic [1:0]     sel_q;
    logic           wd_fire;

    ct_chain #(
        .PRE_W(PRE_W), .CNT_W(CNT_W),
        .DLY_SHORT(DLY_SHORT), .DLY_LONG(DLY_LONG)
    ) u_chain (
        .clk(clk), .por_n(por_n), .restart(wd_fire),
        .delay_long(delay_long), .chain(chain), .running(running)
    );

    ct_tick_gen #(
        .TOT(TOT), .OVF_BIT(OVF_BIT), .RTI_TAP0(RTI_TAP0)
    ) u_tick (
        .chain(chain), .sel(sel_q), .ovf_hit(ovf_hit), .rti_hit(rti_hit)
    );

    ct_ctrl u_ctrl (
        .clk(clk), .por_n(por_n), .restart(wd_fire), .running(running),
        .ovf_hit(ovf_hit), .rti_hit(rti_hit),
        .ovf_clr(ovf_clr), .rti_clr(rti_clr),
        .rate_we(rate_we), .rate_in(rate_in),
        .ovf_flag(ovf_flag), .rti_flag(rti_flag), .sel(sel_q)
    );

    ct_watchdog #(.WD_W(WD_W)) u_wd (
        .clk(clk), .por_n(por_n), .running(running), .enable(wdog_en),
        .clear(wdog_clr), .tick(rti_hit), .fire(wd_fire)
    );

    assign count       = chain[PRE_W+BYTE_W-1:PRE_W];
    assign ovf_irq     = ovf_flag & ovf_ie;
    assign rti_irq     = rti_flag & rti_ie;
    assign wdog_rst    = wd_fire;
    assign rst_release = running;
endmodule

// File: rtl/ct_timer_chk.sv
module ct_timer_chk (
    input logic       clk,
    input logic       por_n,
    input logic       wdog_en,
    input logic       ovf_clr,
    input logic [7:0] count,
    input logic       ovf_flag,
    input logic       rti_flag,
    input logic       wdog_rst,
    input logic       rst_release,
    input logic [1:0] sel_q
);
    assert_quiet_start_R2: assert property (@(posedge clk) disable iff (!por_n)
        !rst_release |-> (!ovf_flag && !rti_flag));

    assert_count_step_R3: assert property (@(posedge clk) disable iff (!por_n)
        rst_release |=> (!rst_release || count == $past(count) ||
                         count == $past(count) + 8'd1));

    assert_ovf_hold_R4: assert property (@(posedge clk) disable iff (!por_n)
        (ovf_flag && !ovf_clr && rst_release) |=> (ovf_flag || !rst_release));

    assert_rate_default_R5: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_release) |-> (sel_q == 2'b11));

    assert_rst_pulse_R7: assert property (@(posedge clk) disable iff (!por_n)
        wdog_rst |=> !wdog_rst);

    assert_rst_restart_R7: assert property (@(posedge clk) disable iff (!por_n)
        wdog_rst |=> !rst_release);

    assert_no_rst_off_R9: assert property (@(posedge clk) disable iff (!por_n)
        !wdog_en |=> !wdog_rst);
endmodule

bind ct_core_timer ct_timer_chk u_chk (
    .clk(clk), .por_n(por_n), .wdog_en(wdog_en), .ovf_clr(ovf_clr),
    .count(count), .ovf_flag(ovf_flag), .rti_flag(rti_flag),
    .wdog_rst(wdog_rst), .rst_release(rst_release), .sel_q(sel_q)
);

// File: tb/tb_ct_core_timer.sv
module tb_ct_core_timer;
    localparam int PRE_W = 3;
    localparam int CNT_W = 11;
    localparam int TAP0  = 10;
    localparam int DLY_S = 32;
    localparam int DLY_L = 8128;
    localparam int TOT   = PRE_W + CNT_W;
    localparam int P0    = 1 << TAP0;

    logic clk = 1'b0;
    logic por_n = 1'b1;
    logic delay_long = 1'b0, rate_we = 1'b0, wdog_en = 1'b0, wdog_clr = 1'b0;
    logic ovf_clr = 1'b0, rti_clr = 1'b0, ovf_ie = 1'b0, rti_ie = 1'b0;
    logic [1:0] rate_in = 2'b00;
    logic [7:0] count;
    logic ovf_flag, rti_flag, ovf_irq, rti_irq, wdog_rst, rst_release;

    int total = 0, bad = 0, cyc = 0, last_clr = 0, wrst_seen = 0;
    int m_t = 0, m_wd = 0, m_rate = 3;
    bit m_ph = 0, m_ovf = 0, m_rti = 0, m_wrst = 0;
    bit n_ov, n_rt, n_fire;
    int n_per;

    always #2 clk = ~clk;

    ct_core_timer #(
        .PRE_W(PRE_W), .CNT_W(CNT_W), .OVF_STAGE(8), .RTI_TAP0(TAP0),
        .WD_W(4), .DLY_SHORT(DLY_S), .DLY_LONG(DLY_L)
    ) dut (
        .clk(clk), .por_n(por_n), .delay_long(delay_long),
        .rate_we(rate_we), .rate_in(rate_in), .wdog_en(wdog_en),
        .wdog_clr(wdog_clr), .ovf_clr(ovf_clr), .rti_clr(rti_clr),
        .ovf_ie(ovf_ie), .rti_ie(rti_ie), .count(count),
        .ovf_flag(ovf_flag), .rti_flag(rti_flag), .ovf_irq(ovf_irq),
        .rti_irq(rti_irq), .wdog_rst(wdog_rst), .rst_release(rst_release)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic cyc_wait(input int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        cyc++;
        if (!por_n || m_wrst) begin
            m_ph = 0; m_t = 0; m_ovf = 0; m_rti = 0;
            m_wd = 0; m_rate = 3; m_wrst = 0;
        end else begin
            if (wdog_clr) last_clr = cyc;
            n_per  = 1 << (TAP0 + m_rate);
            n_ov   = m_ph && ((m_t + 1) % 2048 == 0);
            n_rt   = m_ph && ((m_t + 1) % n_per == 0);
            n_fire = m_ph && wdog_en && n_rt && !wdog_clr && (m_wd == 7);
            if (!m_ph || !wdog_en || wdog_clr || n_fire) m_wd = 0;
            else if (n_rt) m_wd = m_wd + 1;
            m_ovf  = m_ph && (n_ov || (m_ovf && !ovf_clr));
            m_rti  = m_ph && (n_rt || (m_rti && !rti_clr));
            m_wrst = n_fire;
            if (!m_ph) m_rate = 3;
            else if (rate_we) m_rate = rate_in;
            if (!m_ph) begin
                if (m_t == (delay_long ? DLY_L : DLY_S) - 1) begin
                    m_ph = 1; m_t = 0;
                end else m_t = m_t + 1;
            end else m_t = (m_t + 1) % (1 << TOT);
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        chk("R3 count", count, (m_t >> 3) & 255);
        chk("R4 ovf_flag", ovf_flag, m_ovf);
        chk("R5 rti_flag", rti_flag, m_rti);
        chk("R6 ovf_irq", ovf_irq, m_ovf & ovf_ie);
        chk("R6 rti_irq", rti_irq, m_rti & rti_ie);
        chk("R7 wdog_rst", wdog_rst, m_wrst);
        chk("R2 rst_release", rst_release, m_ph);
        if (wdog_rst) wrst_seen++;
    end

    task automatic set_rate(input logic [1:0] v);
        rate_in = v; rate_we = 1'b1;
        cyc_wait(1);
        rate_we = 1'b0;
    endtask

    task automatic pulse_wclr();
        wdog_clr = 1'b1;
        cyc_wait(1);
        wdog_clr = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int e_cyc, r_cyc, s0, c0;
        #1 por_n = 1'b0;
        cyc_wait(3);
        chk("R1 count in reset", count, 0);
        chk("R1 flags in reset", ovf_flag | rti_flag, 0);
        chk("R1 release in reset", rst_release, 0);
        chk("R1 wdog_rst in reset", wdog_rst, 0);
        por_n = 1'b1;
        cyc_wait(40);
        chk("R2 short delay released", rst_release, 1);

        ovf_ie = 1'b1;
        cyc_wait(2100);
        chk("R4 overflow set", ovf_flag, 1);
        chk("R6 overflow request", ovf_irq, 1);
        cyc_wait(300);
        chk("R4 overflow held", ovf_flag, 1);
        ovf_clr = 1'b1;
        cyc_wait(1);
        ovf_clr = 1'b0;
        chk("R4 overflow cleared", ovf_flag, 0);

        rti_ie = 1'b1;
        set_rate(2'b00);
        cyc_wait(3000);
        rti_clr = 1'b1;
        cyc_wait(1);
        rti_clr = 1'b0;
        cyc_wait(500);
        set_rate(2'b01);
        cyc_wait(5000);
        set_rate(2'b10);
        cyc_wait(9000);
        pulse_wclr();
        set_rate(2'b00);

        // R8: regular clears keep the watchdog quiet, count untouched
        pulse_wclr();
        wdog_en = 1'b1;
        s0 = wrst_seen;
        for (int i = 0; i < 4; i++) begin
            cyc_wait(5000);
            c0 = count;
            pulse_wclr();
            chk("R8 count kept across clear", ((count - c0) & 255) <= 1, 1);
        end
        chk("R8 no reset while cleared", wrst_seen - s0, 0);

        // R7: stop clearing and time the reset
        delay_long = 1'b1;
        while (!wdog_rst) cyc_wait(1);
        e_cyc = cyc;
        chk("R7 timeout within 7..8 periods",
            ((e_cyc - last_clr) > 7 * P0) && ((e_cyc - last_clr) <= 8 * P0), 1);
        cyc_wait(1);
        chk("R7 release drops after reset", rst_release, 0);
        chk("R7 pulse is one cycle", wdog_rst, 0);

        while (!rst_release) cyc_wait(1);
        r_cyc = cyc;
        chk("R2 long delay length", r_cyc - e_cyc, DLY_L + 1);
        while (!rti_flag) cyc_wait(1);
        chk("R5 rate back to 11 after restart", cyc - r_cyc, 1 << (TAP0 + 3));

        // R9: disabled watchdog never fires
        wdog_en = 1'b0;
        s0 = wrst_seen;
        set_rate(2'b00);
        cyc_wait(12000);
        chk("R9 no reset while disabled", wrst_seen - s0, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule